// File: doc/BRIEF.md
# Register-Slave Request Guard for TL-UL

This block terminates the request channel of a TL-UL device that fronts a small bank of registers. Each request is classified in the cycle it is accepted. A request is illegal if it breaks a generic TL-UL rule or a rule that comes from the register map. A legal request reads or writes the bank. An illegal one changes nothing and is answered with the error flag set on the response channel.

The register map is a parameter table of word offsets and byte widths. The default map has four registers:

| Offset | Width |
|---|---|
| 0x00 | 4 bytes |
| 0x04 | 2 bytes |
| 0x08 | 1 byte |
| 0x10 | 4 bytes |

Offset 0x0C is left unmapped. Only one transaction is in flight at a time. The request side stops accepting while a response waits to be taken.

Top module: `tlul_reg_guard`

## Requirements
- R1: Only opcodes 0 (PutFullData), 1 (PutPartialData) and 4 (Get) are legal. Any other opcode value is answered with d_error=1 and never writes a register.
- R2: A size value of 3 (above 2) is answered with d_error=1.
- R3: The address must be aligned to the size. With size 1, address bit 0 must be 0. With size 2, address bits 1:0 must be 0. A misaligned request is answered with d_error=1.
- R4: The allowed byte lanes depend on size and address:
  - size 0: lane `addr[1:0]` only
  - size 1: lanes 1:0 when `addr[1]`=0, lanes 3:2 when `addr[1]`=1
  - size 2: all four lanes

  A mask bit set outside these lanes gives d_error=1.
- R5: A PutFullData whose mask does not equal the full lane set of R4 gives d_error=1.
- R6: An address whose word matches no table offset gives d_error=1 when dev_mode_i=1. With dev_mode_i=0 the same access gives d_error=0: a read returns zero and a write changes nothing.
- R7: A write to a mapped register with address bits 1:0 nonzero gives d_error=1.
- R8: A write to a mapped register of W bytes must set mask bits W-1..0. Otherwise d_error=1. Mask bits above W are ignored.
- R9: A legal read returns the whole register word, zero-extended to 32 bits, whatever its mask and size.
- R10: An errored Get returns d_data=0xFFFFFFFF. An errored request leaves every register unchanged.
- R11: The response appears on the cycle after acceptance. d_opcode is 1 (AccessAckData) for Get and 0 (AccessAck) otherwise. The request's source and size are echoed.
- R12: While a response is pending, a_ready_o is 0. The response and its data are held until d_ready_i is 1.
- R13: After reset, d_valid_o=0, a_ready_o=1 and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_mode_i | input | 1 | Device mode; makes unmapped accesses errors |
| a_valid_i | input | 1 | Request valid |
| a_ready_o | output | 1 | Request accepted when high with a_valid_i |
| a_opcode_i | input | 3 | Request opcode |
| a_size_i | input | 2 | Log2 of access bytes |
| a_source_i | input | SourceW | Requester ID |
| a_address_i | input | AW | Byte address |
| a_mask_i | input | 4 | Byte-lane enables |
| a_data_i | input | 32 | Write data |
| d_valid_o | output | 1 | Response valid |
| d_ready_i | input | 1 | Response taken when high with d_valid_o |
| d_opcode_o | output | 3 | Response opcode |
| d_size_o | output | 2 | Echoed size |
| d_source_o | output | SourceW | Echoed requester ID |
| d_data_o | output | 32 | Read data |
| d_error_o | output | 1 | Request was rejected |

## Verification
The bench builds the block with its defaults: 8-bit addresses, a 4-bit source and the four-entry map described above. The 1-byte and 2-byte registers make the narrow-write rule observable, including a case where a mask is rejected on the 4-byte register but legal on the 1-byte one. Because a PutFullData and a PutPartialData with the same mask reach the 1-byte register, the full-mask rule can be told apart from the width rule. The 0x0C hole inside a small address space lets the device-mode switch be tried on both settings between real registers.

// File: rtl/tlg_pkg.sv
package tlg_pkg;

  localparam logic [2:0] OP_PUT_FULL = 3'd0;
  localparam logic [2:0] OP_PUT_PART = 3'd1;
  localparam logic [2:0] OP_GET      = 3'd4;

  localparam logic [2:0] RSP_ACK      = 3'd0;
  localparam logic [2:0] RSP_ACK_DATA = 3'd1;

  // Byte lanes a request of the given size may touch at this address.
  function automatic logic [3:0] lanes_of(input logic [1:0] size, input logic [1:0] lo);
    case (size)
      2'd0:    lanes_of = 4'b0001 << lo;
      2'd1:    lanes_of = lo[1] ? 4'b1100 : 4'b0011;
      2'd2:    lanes_of = 4'b1111;
      default: lanes_of = 4'b0000;
    endcase
  endfunction

  // Low-byte mask that covers a register of the given byte width.
  function automatic logic [3:0] width_mask(input logic [2:0] nbytes);
    case (nbytes)
      3'd1:    width_mask = 4'b0001;
      3'd2:    width_mask = 4'b0011;
      3'd3:    width_mask = 4'b0111;
      default: width_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/tlg_map_decode.sv
module tlg_map_decode #(
  parameter int AW      = 8,
  parameter int NumRegs = 4,
  parameter logic [NumRegs*AW-1:0] RegOffsets = {8'h10, 8'h08, 8'h04, 8'h00},
  parameter logic [NumRegs*3-1:0]  RegBytes   = {3'd4, 3'd1, 3'd2, 3'd4}
) (
  input  logic [AW-1:0]      addr,
  output logic               hit,
  output logic [NumRegs-1:0] sel,
  output logic [2:0]         nbytes
);

  localparam int WordAW = AW - 2;

  for (genvar i = 0; i < NumRegs; i++) begin : g_cmp
    assign sel[i] = (addr[AW-1:2] == RegOffsets[i*AW+2 +: WordAW]);
  end

  always_comb begin
    hit    = |sel;
    nbytes = 3'd0;
    for (int i = 0; i < NumRegs; i++) begin
      if (sel[i]) nbytes = nbytes | RegBytes[i*3 +: 3];
    end
  end

endmodule

// File: rtl/tlg_req_check.sv
module tlg_req_check
  import tlg_pkg::*;
(
  input  logic [2:0] opcode,
  input  logic [1:0] size,
  input  logic [1:0] addr_lo,
  input  logic [3:0] mask,
  input  logic       hit,
  input  logic [2:0] nbytes,
  input  logic       dev_mode,
  output logic       is_write,
  output logic       is_read,
  output logic       err
);

  logic [3:0] lanes;
  logic       op_ok, size_ok, align_ok, lane_ok, full_ok, map_ok, wr_lo_ok, wr_w_ok;
  logic [3:0] need;

  always_comb begin
    is_write = (opcode == OP_PUT_FULL) || (opcode == OP_PUT_PART);
    is_read  = (opcode == OP_GET);
    op_ok    = is_write || is_read;
    size_ok  = (size != 2'd3);
    case (size)
      2'd0:    align_ok = 1'b1;
      2'd1:    align_ok = !addr_lo[0];
      2'd2:    align_ok = (addr_lo == 2'd0);
      default: align_ok = 1'b0;
    endcase
    lanes    = lanes_of(size, addr_lo);
    lane_ok  = ((mask & ~lanes) == 4'd0);
    full_ok  = (opcode != OP_PUT_FULL) || (mask == lanes);
    map_ok   = hit || !dev_mode;
    need     = width_mask(nbytes);
    wr_lo_ok = !(is_write && hit && (addr_lo != 2'd0));
    wr_w_ok  = !(is_write && hit) || ((mask & need) == need);
    err      = !(op_ok && size_ok && align_ok && lane_ok && full_ok &&
                 map_ok && wr_lo_ok && wr_w_ok);
  end

endmodule

// File: rtl/tlg_reg_bank.sv
module tlg_reg_bank #(
  parameter int NumRegs = 4,
  parameter int DataW   = 32,
  parameter logic [NumRegs*3-1:0] RegBytes = {3'd4, 3'd1, 3'd2, 3'd4}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [NumRegs-1:0]       sel,
  input  logic [DataW/8-1:0]       be,
  input  logic [DataW-1:0]         wdata,
  output logic [NumRegs*DataW-1:0] q_flat
);

  localparam int NumLanes = DataW / 8;

  for (genvar i = 0; i < NumRegs; i++) begin : g_reg
    for (genvar b = 0; b < NumLanes; b++) begin : g_lane
      if (b < RegBytes[i*3 +: 3]) begin : g_store
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
          if (rst)                       byte_q <= 8'h00;
          else if (we && sel[i] && be[b]) byte_q <= wdata[b*8 +: 8];
        end
        assign q_flat[i*DataW + b*8 +: 8] = byte_q;
      end else begin : g_tie
        assign q_flat[i*DataW + b*8 +: 8] = 8'h00;
      end
    end
  end

endmodule

// File: rtl/tlul_reg_guard.sv
module tlul_reg_guard
  import tlg_pkg::*;
#(
  parameter int AW      = 8,
  parameter int SourceW = 4,
  parameter int NumRegs = 4,
  parameter logic [NumRegs*AW-1:0] RegOffsets = {8'h10, 8'h08, 8'h04, 8'h00},
  parameter logic [NumRegs*3-1:0]  RegBytes   = {3'd4, 3'd1, 3'd2, 3'd4}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dev_mode_i,
  input  logic               a_valid_i,
  output logic               a_ready_o,
  input  logic [2:0]         a_opcode_i,
  input  logic [1:0]         a_size_i,
  input  logic [SourceW-1:0] a_source_i,
  input  logic [AW-1:0]      a_address_i,
  input  logic [3:0]         a_mask_i,
  input  logic [31:0]        a_data_i,
  output logic               d_valid_o,
  input  logic               d_ready_i,
  output logic [2:0]         d_opcode_o,
  output logic [1:0]         d_size_o,
  output logic [SourceW-1:0] d_source_o,
  output logic [31:0]        d_data_o,
  output logic               d_error_o
);

  localparam int DataW = 32;

  logic               hit, is_write, is_read, err, accept, we;
  logic [NumRegs-1:0] sel;
  logic [2:0]         nbytes;
  logic [NumRegs*DataW-1:0] q_flat;
  logic [DataW-1:0]   rdata;

  tlg_map_decode #(
    .AW(AW), .NumRegs(NumRegs), .RegOffsets(RegOffsets), .RegBytes(RegBytes)
  ) u_map (
    .addr(a_address_i), .hit(hit), .sel(sel), .nbytes(nbytes)
  );

  tlg_req_check u_chk (
    .opcode(a_opcode_i), .size(a_size_i), .addr_lo(a_address_i[1:0]),
    .mask(a_mask_i), .hit(hit), .nbytes(nbytes), .dev_mode(dev_mode_i),
    .is_write(is_write), .is_read(is_read), .err(err)
  );

  assign a_ready_o = !d_valid_o;
  assign accept    = a_valid_i && a_ready_o;
  assign we        = accept && is_write && !err;

  tlg_reg_bank #(
    .NumRegs(NumRegs), .DataW(DataW), .RegBytes(RegBytes)
  ) u_bank (
    .clk(clk), .rst(rst), .we(we), .sel(sel), .be(a_mask_i),
    .wdata(a_data_i), .q_flat(q_flat)
  );

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NumRegs; i++) begin
      if (sel[i]) rdata = rdata | q_flat[i*DataW +: DataW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_valid_o  <= 1'b0;
      d_opcode_o <= RSP_ACK;
      d_size_o   <= '0;
      d_source_o <= '0;
      d_data_o   <= '0;
      d_error_o  <= 1'b0;
    end else if (accept) begin
      d_valid_o  <= 1'b1;
      d_opcode_o <= is_read ? RSP_ACK_DATA : RSP_ACK;
      d_size_o   <= a_size_i;
      d_source_o <= a_source_i;
      d_data_o   <= !is_read ? '0 : (err ? '1 : rdata);
      d_error_o  <= err;
    end else if (d_ready_i) begin
      d_valid_o  <= 1'b0;
    end
  end

  a_r11_echo: assert property (@(posedge clk) disable iff (rst)
    accept |=> d_valid_o && d_source_o == $past(a_source_i) && d_size_o == $past(a_size_i));

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    d_valid_o && !d_ready_i |=> d_valid_o && $stable(d_data_o) && $stable(d_error_o));

  a_r12_one_pending: assert property (@(posedge clk) disable iff (rst)
    accept |=> !a_ready_o);

  a_r2_big_size: assert property (@(posedge clk) disable iff (rst)
    accept && a_size_i == 2'd3 |=> d_error_o);

  a_r1_bad_opcode: assert property (@(posedge clk) disable iff (rst)
    accept && a_opcode_i != OP_GET && a_opcode_i != OP_PUT_FULL && a_opcode_i != OP_PUT_PART
    |=> d_error_o);

  a_r10_err_read_ones: assert property (@(posedge clk) disable iff (rst)
    d_valid_o && d_error_o && d_opcode_o == RSP_ACK_DATA |-> d_data_o == 32'hFFFF_FFFF);

  a_r10_err_no_write: assert property (@(posedge clk) disable iff (rst)
    accept && err |=> $stable(q_flat));

endmodule

// File: tb/test_tlul_reg_guard.sv
module test_tlul_reg_guard;

  logic        clk = 1'b0;
  logic        rst;
  logic        dev_mode, a_valid, a_ready, d_valid, d_ready, d_error;
  logic [2:0]  a_opcode, d_opcode;
  logic [1:0]  a_size, d_size;
  logic [3:0]  a_source, d_source, a_mask;
  logic [7:0]  a_address;
  logic [31:0] a_data, d_data;

  int n_vec = 0;
  int n_bad = 0;

  logic        r_err;
  logic [31:0] r_data;
  logic [2:0]  r_op;
  logic [3:0]  r_src;
  logic [1:0]  r_size;

  always #2 clk = ~clk;

  tlul_reg_guard i_tlul_reg_guard (
    .clk(clk), .rst(rst), .dev_mode_i(dev_mode),
    .a_valid_i(a_valid), .a_ready_o(a_ready), .a_opcode_i(a_opcode),
    .a_size_i(a_size), .a_source_i(a_source), .a_address_i(a_address),
    .a_mask_i(a_mask), .a_data_i(a_data),
    .d_valid_o(d_valid), .d_ready_i(d_ready), .d_opcode_o(d_opcode),
    .d_size_o(d_size), .d_source_o(d_source), .d_data_o(d_data),
    .d_error_o(d_error)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, accepted at the next rising edge, response sampled one falling edge later.
  task automatic req(input logic [2:0] op, input logic [7:0] addr, input logic [1:0] size,
                     input logic [3:0] mask, input logic [31:0] data, input logic [3:0] src);
    a_opcode = op; a_address = addr; a_size = size; a_mask = mask; a_data = data;
    a_source = src; a_valid = 1'b1;
    @(negedge clk);
    a_valid = 1'b0;
    r_err = d_error; r_data = d_data; r_op = d_opcode; r_src = d_source; r_size = d_size;
    check("R11 response valid", {31'd0, d_valid}, 32'd1);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] addr, output logic [31:0] v);
    req(3'd4, addr, 2'd2, 4'hF, 32'd0, 4'd0);
    v = r_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R13 a_ready", {31'd0, a_ready}, 32'd1);
    check("R13 d_valid", {31'd0, d_valid}, 32'd0);
    rd(8'h00, v); check("R13 reg00", v, 32'd0);
    rd(8'h10, v); check("R13 reg10", v, 32'd0);
  endtask

  task automatic t_basic;
    req(3'd0, 8'h00, 2'd2, 4'hF, 32'hDEADBEEF, 4'd3);
    check("R11 write opcode", {29'd0, r_op}, 32'd0);
    check("R11 source", {28'd0, r_src}, 32'd3);
    check("R11 size", {30'd0, r_size}, 32'd2);
    check("R11 write err", {31'd0, r_err}, 32'd0);
    req(3'd4, 8'h00, 2'd0, 4'b0001, 32'd0, 4'd9);
    check("R9 byte read full word", r_data, 32'hDEADBEEF);
    check("R11 read opcode", {29'd0, r_op}, 32'd1);
    check("R11 read size", {30'd0, r_size}, 32'd0);
    req(3'd4, 8'h02, 2'd1, 4'b1100, 32'd0, 4'd1);
    check("R9 half read full word", r_data, 32'hDEADBEEF);
    req(3'd1, 8'h10, 2'd2, 4'hF, 32'hCAFEF00D, 4'd2);
    check("R11 partial write ok", {31'd0, r_err}, 32'd0);
  endtask

  task automatic t_narrow;
    logic [31:0] v;
    req(3'd1, 8'h04, 2'd2, 4'b0011, 32'h12345678, 4'd0);
    check("R8 2-byte write ok", {31'd0, r_err}, 32'd0);
    rd(8'h04, v); check("R9 zero-extend 2-byte", v, 32'h00005678);
    req(3'd1, 8'h04, 2'd2, 4'b0001, 32'h0000AAAA, 4'd0);
    check("R8 narrow write err", {31'd0, r_err}, 32'd1);
    rd(8'h04, v); check("R10 kept after err", v, 32'h00005678);
    req(3'd1, 8'h00, 2'd0, 4'b0001, 32'h00000011, 4'd0);
    check("R8 byte to 4-byte reg err", {31'd0, r_err}, 32'd1);
    rd(8'h00, v); check("R10 reg00 kept", v, 32'hDEADBEEF);
    req(3'd1, 8'h08, 2'd0, 4'b0001, 32'h000000AB, 4'd0);
    check("R8 byte to 1-byte reg ok", {31'd0, r_err}, 32'd0);
    rd(8'h08, v); check("R9 1-byte reg", v, 32'h000000AB);
    req(3'd1, 8'h09, 2'd0, 4'b0010, 32'h00001100, 4'd0);
    check("R7 unaligned write err", {31'd0, r_err}, 32'd1);
    rd(8'h08, v); check("R7 reg08 kept", v, 32'h000000AB);
  endtask

  task automatic t_full_mask;
    logic [31:0] v;
    req(3'd0, 8'h08, 2'd1, 4'b0001, 32'h000000CD, 4'd0);
    check("R5 put-full short mask err", {31'd0, r_err}, 32'd1);
    rd(8'h08, v); check("R5 reg08 kept", v, 32'h000000AB);
    req(3'd1, 8'h08, 2'd1, 4'b0001, 32'h000000CD, 4'd0);
    check("R5 put-partial same mask ok", {31'd0, r_err}, 32'd0);
    rd(8'h08, v); check("R5 reg08 written", v, 32'h000000CD);
  endtask

  task automatic t_generic;
    logic [31:0] v;
    req(3'd2, 8'h10, 2'd2, 4'hF, 32'h0, 4'd0);
    check("R1 opcode 2 err", {31'd0, r_err}, 32'd1);
    req(3'd7, 8'h10, 2'd2, 4'hF, 32'h11111111, 4'd0);
    check("R1 opcode 7 err", {31'd0, r_err}, 32'd1);
    rd(8'h10, v); check("R1 reg10 kept", v, 32'hCAFEF00D);
    req(3'd4, 8'h10, 2'd3, 4'hF, 32'h0, 4'd0);
    check("R2 size 3 err", {31'd0, r_err}, 32'd1);
    check("R10 err read ones", r_data, 32'hFFFFFFFF);
    req(3'd4, 8'h01, 2'd1, 4'b0110, 32'h0, 4'd0);
    check("R3 half misaligned", {31'd0, r_err}, 32'd1);
    req(3'd4, 8'h02, 2'd2, 4'hF, 32'h0, 4'd0);
    check("R3 word misaligned", {31'd0, r_err}, 32'd1);
    req(3'd4, 8'h00, 2'd0, 4'b0010, 32'h0, 4'd0);
    check("R4 lane outside", {31'd0, r_err}, 32'd1);
    req(3'd4, 8'h00, 2'd0, 4'b0001, 32'h0, 4'd0);
    check("R4 lane inside", {31'd0, r_err}, 32'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    dev_mode = 1'b1;
    req(3'd4, 8'h0C, 2'd2, 4'hF, 32'h0, 4'd0);
    check("R6 dev read err", {31'd0, r_err}, 32'd1);
    check("R6 dev read ones", r_data, 32'hFFFFFFFF);
    dev_mode = 1'b0;
    req(3'd4, 8'h0C, 2'd2, 4'hF, 32'h0, 4'd0);
    check("R6 nondev read ok", {31'd0, r_err}, 32'd0);
    check("R6 nondev read zero", r_data, 32'd0);
    req(3'd0, 8'h0C, 2'd2, 4'hF, 32'h55555555, 4'd0);
    check("R6 nondev write ok", {31'd0, r_err}, 32'd0);
    rd(8'h10, v); check("R6 reg10 kept", v, 32'hCAFEF00D);
    rd(8'h00, v); check("R6 reg00 kept", v, 32'hDEADBEEF);
  endtask

  task automatic t_stall;
    d_ready = 1'b0;
    a_opcode = 3'd4; a_address = 8'h00; a_size = 2'd2; a_mask = 4'hF; a_source = 4'd5;
    a_valid = 1'b1;
    @(negedge clk);
    a_address = 8'h10; a_source = 4'd6;
    check("R12 a_ready low", {31'd0, a_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    check("R12 held valid", {31'd0, d_valid}, 32'd1);
    check("R12 held data", d_data, 32'hDEADBEEF);
    check("R12 held source", {28'd0, d_source}, 32'd5);
    d_ready = 1'b1;
    @(negedge clk);
    check("R12 ready after take", {31'd0, a_ready}, 32'd1);
    @(negedge clk);
    a_valid = 1'b0;
    check("R12 second response", d_data, 32'hCAFEF00D);
    check("R12 second source", {28'd0, d_source}, 32'd6);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; dev_mode = 1'b0; a_valid = 1'b0; d_ready = 1'b1;
    a_opcode = 3'd0; a_size = 2'd0; a_source = 4'd0; a_address = 8'd0;
    a_mask = 4'd0; a_data = 32'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_basic;
    t_narrow;
    t_full_mask;
    t_generic;
    t_unmapped;
    t_stall;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule